// File: doc/BRIEF.md
# Interrupt CPU Interface: Acknowledge and Completion Logic

This block is the per-processor register face of an interrupt controller. Each processor context reaches it through one shared register port, with a context number on every request. For each context it keeps an enable bit, a priority mask, a binary-point field and a running priority. It also keeps a local copy of the highest-priority pending interrupt, which the prioritisation logic outside the block loads through a strobe. From that state it drives one interrupt request line per context.

A read of the acknowledge register hands the recorded interrupt to software and marks the record as consumed. The block then sends a one-cycle clear toward the distributor's pending state and asks for the pending state to be evaluated again. A write to the completion register ends the handling of an interrupt. For a software interrupt it produces a one-hot mask that selects one bit of a 64-bit record, at the position given by the target context and the source processor. For an ordinary interrupt it clears the active bit that the block keeps. In both cases the running priority goes back to idle.

Top module: `irq_cpuif`

## Requirements
- R1: After reset every context has enable 0, priority mask 0, binary point 0 and running priority all-ones (0xFF). All IRQ lines are low, the active vector is zero, no pulse is driven, and an acknowledge read returns 1023.
- R2: Register index 0 (enable, bit 0), index 1 (priority mask, bits PRIO_W-1:0) and index 2 (binary point, bits 2:0) store the write data for the requesting context only, and read back zero-extended.
- R3: A read drives reg_rvalid and the data one cycle after the request. The identification register (index 15), the completion register (index 4) and unmapped indices read as 0.
- R4: irq[c] is high exactly when context c holds a recorded ID other than 1023, dist_enable is set, context c's enable is set, and the recorded priority is numerically lower than its priority mask.
- R5: An acknowledge read (index 3) returns 1023 and changes no state when dist_enable or the context's enable is clear, or when the record already holds 1023.
- R6: A successful acknowledge read returns the ID in bits 9:0 and the source CPU in bits 12:10. The context's record becomes 1023, its IRQ drops, and one cycle later clr_valid pulses with the ID, the source and the context. The running priority takes the acknowledged interrupt's priority.
- R7: hp_load[c] copies hp_id, hp_src and hp_prio of context c into its record. A successful acknowledge by the same context in the same cycle takes precedence, and the record becomes 1023.
- R8: A completion write (index 4) whose ID (bits 9:0) is below 16 pulses eoi_valid. eoi_sgi_mask then has exactly bit (ctx + 8 * source), with the source taken from bits 12:10.
- R9: Every completion write sets that context's running priority to 0xFF. For an ID of 16 or above, eoi_sgi_mask is zero and the active bit of that ID is cleared.
- R10: A successful acknowledge of an ID from 16 to NUM_INTS-1 sets that ID's active bit.
- R11: eval_req[c] pulses one cycle after a successful acknowledge by context c. It also pulses one cycle after any write by context c when c's enable, with that write applied, is set.
- R12: The running-priority register (index 5) reads back the context's running priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register request present this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register index |
| reg_ctx | input | CTX_W | Requesting processor context |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| dist_enable | input | 1 | Distributor global enable |
| hp_load | input | NUM_CPUS | Per-context strobe that loads the pending record |
| hp_id | input | NUM_CPUS*10 | Per-context highest pending ID |
| hp_src | input | NUM_CPUS*3 | Per-context source CPU of that ID |
| hp_prio | input | NUM_CPUS*PRIO_W | Per-context priority of that ID |
| irq | output | NUM_CPUS | Interrupt request line per context |
| eval_req | output | NUM_CPUS | Request to evaluate the pending state again |
| clr_valid | output | 1 | Acknowledge clear pulse toward the pending state |
| clr_id | output | 10 | ID being cleared |
| clr_src | output | 3 | Source CPU of the cleared ID |
| clr_ctx | output | CTX_W | Context that acknowledged |
| eoi_valid | output | 1 | Completion pulse |
| eoi_id | output | 10 | Completed ID |
| eoi_sgi_mask | output | 64 | One-hot software-interrupt clear mask |
| active | output | NUM_INTS | Active bit per interrupt ID |

## Verification
The block registers every request result once. Read data, clr_valid, eoi_valid, eoi_sgi_mask and eval_req appear in the cycle after the edge that samples the request. The active bits, the running priority and the record also change at that edge. The IRQ lines follow the state and dist_enable through logic alone, so they change in the same cycle as the state they depend on. The bench drives inputs just after the rising edge. A reference model updates on the rising edge, and all outputs are compared with it on the falling edge, where each result is already due.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
   localparam int unsigned DATA_W  = 32;
   localparam int unsigned ADDR_W  = 4;
   localparam int unsigned ID_W    = 10;
   localparam int unsigned SRC_W   = 3;
   localparam int unsigned BINPT_W = 3;
   localparam int unsigned SGI_STRIDE = 8;
   localparam int unsigned SGI_MASK_W = SGI_STRIDE * (1 << SRC_W);
   localparam int unsigned SGI_BIT_W  = $clog2(SGI_MASK_W);

   localparam logic [ID_W-1:0] SPUR_ID   = 10'd1023;
   localparam logic [ID_W-1:0] SGI_LIMIT = 10'd16;

   typedef enum logic [ADDR_W-1:0] {
      RG_CTRL   = 4'd0,
      RG_PMASK  = 4'd1,
      RG_BINPT  = 4'd2,
      RG_ACK    = 4'd3,
      RG_EOI    = 4'd4,
      RG_RUNPRI = 4'd5,
      RG_IDENT  = 4'd15
   } reg_sel_e;

   function automatic logic [DATA_W-1:0] pack_ack(input logic [SRC_W-1:0] src,
                                                  input logic [ID_W-1:0] id);
      return {{(DATA_W-SRC_W-ID_W){1'b0}}, src, id};
   endfunction
endpackage

// File: rtl/cpuif_decode.sv
module cpuif_decode
   import cpuif_pkg::*;
#(
   parameter int unsigned NUM_CPUS = 4,
   parameter int unsigned CTX_W    = 2
) (
   input  logic                reg_valid,
   input  logic                reg_write,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [CTX_W-1:0]    reg_ctx,
   output logic                ctx_ok,
   output logic [NUM_CPUS-1:0] wr_any,
   output logic [NUM_CPUS-1:0] wr_ctrl,
   output logic [NUM_CPUS-1:0] wr_pmask,
   output logic [NUM_CPUS-1:0] wr_binpt,
   output logic [NUM_CPUS-1:0] wr_eoi,
   output logic [NUM_CPUS-1:0] rd_ack
);
   logic [NUM_CPUS-1:0] hit;

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_ctx
      assign hit[c]      = reg_valid && (reg_ctx == CTX_W'(c));
      assign wr_any[c]   = hit[c] && reg_write;
      assign wr_ctrl[c]  = wr_any[c] && (reg_addr == RG_CTRL);
      assign wr_pmask[c] = wr_any[c] && (reg_addr == RG_PMASK);
      assign wr_binpt[c] = wr_any[c] && (reg_addr == RG_BINPT);
      assign wr_eoi[c]   = wr_any[c] && (reg_addr == RG_EOI);
      assign rd_ack[c]   = hit[c] && !reg_write && (reg_addr == RG_ACK);
   end

   assign ctx_ok = |hit;
endmodule

// File: rtl/cpuif_cpu_bank.sv
module cpuif_cpu_bank
   import cpuif_pkg::*;
#(
   parameter int unsigned PRIO_W  = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PRIO_W-1:0]  wdata,
   input  logic               wr_ctrl,
   input  logic               wr_pmask,
   input  logic               wr_binpt,
   input  logic               wr_eoi,
   input  logic               rd_ack,
   input  logic               dist_enable,
   input  logic               hp_load,
   input  logic [ID_W-1:0]    hp_id,
   input  logic [SRC_W-1:0]   hp_src,
   input  logic [PRIO_W-1:0]  hp_prio,
   output logic               ctrl_en,
   output logic [PRIO_W-1:0]  pmask,
   output logic [BINPT_W-1:0] binpt,
   output logic [PRIO_W-1:0]  runpri,
   output logic [ID_W-1:0]    rec_id,
   output logic [SRC_W-1:0]   rec_src,
   output logic [PRIO_W-1:0]  rec_prio,
   output logic               ack_ok,
   output logic               irq
);
   localparam logic [PRIO_W-1:0] PRIO_IDLE = {PRIO_W{1'b1}};

   logic irq_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en <= 1'b0;
         pmask   <= '0;
         binpt   <= '0;
      end else begin
         if (wr_ctrl)  ctrl_en <= wdata[0];
         if (wr_pmask) pmask   <= wdata;
         if (wr_binpt) binpt   <= wdata[BINPT_W-1:0];
      end
   end

   assign ack_ok = rd_ack && dist_enable && ctrl_en && (rec_id != SPUR_ID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_id   <= SPUR_ID;
         rec_src  <= '0;
         rec_prio <= PRIO_IDLE;
      end else if (ack_ok) begin
         rec_id   <= SPUR_ID;
      end else if (hp_load) begin
         rec_id   <= hp_id;
         rec_src  <= hp_src;
         rec_prio <= hp_prio;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       runpri <= PRIO_IDLE;
      else if (ack_ok)  runpri <= rec_prio;
      else if (wr_eoi)  runpri <= PRIO_IDLE;
   end

   assign irq_c = (rec_id != SPUR_ID) && dist_enable && ctrl_en && (rec_prio < pmask);

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_c;
      end
   end else begin : g_irq_comb
      assign irq = irq_c;
   end
endmodule

// File: rtl/cpuif_eoi_unit.sv
module cpuif_eoi_unit
   import cpuif_pkg::*;
#(
   parameter int unsigned NUM_INTS = 64,
   parameter int unsigned CTX_W    = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  eoi_req,
   input  logic [CTX_W-1:0]      eoi_ctx,
   input  logic [ID_W-1:0]       eoi_in_id,
   input  logic [SRC_W-1:0]      eoi_in_src,
   input  logic                  ack_req,
   input  logic [ID_W-1:0]       ack_id,
   output logic                  eoi_valid,
   output logic [ID_W-1:0]       eoi_id,
   output logic [SGI_MASK_W-1:0] eoi_sgi_mask,
   output logic [NUM_INTS-1:0]   active
);
   logic                 is_sgi;
   logic [SGI_BIT_W-1:0] sgi_bit;

   assign is_sgi  = eoi_in_id < SGI_LIMIT;
   assign sgi_bit = {eoi_in_src, {$clog2(SGI_STRIDE){1'b0}}} + SGI_BIT_W'(eoi_ctx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoi_valid    <= 1'b0;
         eoi_id       <= '0;
         eoi_sgi_mask <= '0;
      end else begin
         eoi_valid    <= eoi_req;
         eoi_id       <= eoi_req ? eoi_in_id : '0;
         eoi_sgi_mask <= (eoi_req && is_sgi) ? (SGI_MASK_W'(1) << sgi_bit) : '0;
      end
   end

   for (genvar i = 0; i < NUM_INTS; i++) begin : g_act
      if (i < 16) begin : g_sgi
         assign active[i] = 1'b0;
      end else begin : g_track
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   active[i] <= 1'b0;
            else if (eoi_req && eoi_in_id == ID_W'(i))    active[i] <= 1'b0;
            else if (ack_req && ack_id == ID_W'(i))       active[i] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_cpuif.sv
module irq_cpuif
   import cpuif_pkg::*;
#(
   parameter int unsigned NUM_CPUS = 4,
   parameter int unsigned NUM_INTS = 64,
   parameter int unsigned PRIO_W   = 8,
   parameter bit          IRQ_REG  = 1'b0,
   parameter int unsigned CTX_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_valid,
   input  logic                       reg_write,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [CTX_W-1:0]           reg_ctx,
   input  logic [DATA_W-1:0]          reg_wdata,
   output logic                       reg_rvalid,
   output logic [DATA_W-1:0]          reg_rdata,
   input  logic                       dist_enable,
   input  logic [NUM_CPUS-1:0]        hp_load,
   input  logic [NUM_CPUS*ID_W-1:0]   hp_id,
   input  logic [NUM_CPUS*SRC_W-1:0]  hp_src,
   input  logic [NUM_CPUS*PRIO_W-1:0] hp_prio,
   output logic [NUM_CPUS-1:0]        irq,
   output logic [NUM_CPUS-1:0]        eval_req,
   output logic                       clr_valid,
   output logic [ID_W-1:0]            clr_id,
   output logic [SRC_W-1:0]           clr_src,
   output logic [CTX_W-1:0]           clr_ctx,
   output logic                       eoi_valid,
   output logic [ID_W-1:0]            eoi_id,
   output logic [SGI_MASK_W-1:0]      eoi_sgi_mask,
   output logic [NUM_INTS-1:0]        active
);
   localparam int unsigned CTX_W_EXP = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
   localparam int unsigned SRC_TOP   = ID_W + SRC_W;

   initial begin
      if (NUM_CPUS < 1 || NUM_CPUS > SGI_STRIDE)
         $error("irq_cpuif: NUM_CPUS must be 1..%0d", SGI_STRIDE);
      if (CTX_W != CTX_W_EXP)
         $error("irq_cpuif: CTX_W is derived and must not be overridden");
      if (PRIO_W < BINPT_W || PRIO_W > 8)
         $error("irq_cpuif: PRIO_W must be %0d..8", BINPT_W);
      if (NUM_INTS < 17 || NUM_INTS > 1020)
         $error("irq_cpuif: NUM_INTS must be 17..1020");
   end

   logic                ctx_ok;
   logic [NUM_CPUS-1:0] wr_any, wr_ctrl, wr_pmask, wr_binpt, wr_eoi, rd_ack;
   logic [NUM_CPUS-1:0] ctrl_en, ack_ok, new_en;
   logic [PRIO_W-1:0]   pmask_a  [NUM_CPUS];
   logic [BINPT_W-1:0]  binpt_a  [NUM_CPUS];
   logic [PRIO_W-1:0]   runpri_a [NUM_CPUS];
   logic [ID_W-1:0]     rec_id_a [NUM_CPUS];
   logic [SRC_W-1:0]    rec_src_a[NUM_CPUS];
   logic [PRIO_W-1:0]   rec_pri_a[NUM_CPUS];
   logic                ack_any;
   logic [DATA_W-1:0]   rd_mux;
   logic                unused_wdata_hi;

   assign unused_wdata_hi = ^reg_wdata[DATA_W-1:SRC_TOP];

   cpuif_decode #(.NUM_CPUS(NUM_CPUS), .CTX_W(CTX_W)) u_dec (
      .reg_valid (reg_valid),
      .reg_write (reg_write),
      .reg_addr  (reg_addr),
      .reg_ctx   (reg_ctx),
      .ctx_ok    (ctx_ok),
      .wr_any    (wr_any),
      .wr_ctrl   (wr_ctrl),
      .wr_pmask  (wr_pmask),
      .wr_binpt  (wr_binpt),
      .wr_eoi    (wr_eoi),
      .rd_ack    (rd_ack)
   );

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      cpuif_cpu_bank #(.PRIO_W(PRIO_W), .IRQ_REG(IRQ_REG)) u_bank (
         .clk         (clk),
         .rst_n       (rst_n),
         .wdata       (reg_wdata[PRIO_W-1:0]),
         .wr_ctrl     (wr_ctrl[c]),
         .wr_pmask    (wr_pmask[c]),
         .wr_binpt    (wr_binpt[c]),
         .wr_eoi      (wr_eoi[c]),
         .rd_ack      (rd_ack[c]),
         .dist_enable (dist_enable),
         .hp_load     (hp_load[c]),
         .hp_id       (hp_id[c*ID_W +: ID_W]),
         .hp_src      (hp_src[c*SRC_W +: SRC_W]),
         .hp_prio     (hp_prio[c*PRIO_W +: PRIO_W]),
         .ctrl_en     (ctrl_en[c]),
         .pmask       (pmask_a[c]),
         .binpt       (binpt_a[c]),
         .runpri      (runpri_a[c]),
         .rec_id      (rec_id_a[c]),
         .rec_src     (rec_src_a[c]),
         .rec_prio    (rec_pri_a[c]),
         .ack_ok      (ack_ok[c]),
         .irq         (irq[c])
      );
      assign new_en[c] = wr_ctrl[c] ? reg_wdata[0] : ctrl_en[c];
   end

   assign ack_any = |ack_ok;

   cpuif_eoi_unit #(.NUM_INTS(NUM_INTS), .CTX_W(CTX_W)) u_eoi (
      .clk          (clk),
      .rst_n        (rst_n),
      .eoi_req      (|wr_eoi),
      .eoi_ctx      (reg_ctx),
      .eoi_in_id    (reg_wdata[ID_W-1:0]),
      .eoi_in_src   (reg_wdata[SRC_TOP-1:ID_W]),
      .ack_req      (ack_any),
      .ack_id       (rec_id_a[reg_ctx]),
      .eoi_valid    (eoi_valid),
      .eoi_id       (eoi_id),
      .eoi_sgi_mask (eoi_sgi_mask),
      .active       (active)
   );

   always_comb begin
      rd_mux = '0;
      if (ctx_ok) begin
         case (reg_addr)
            RG_CTRL:   rd_mux = {{(DATA_W-1){1'b0}}, ctrl_en[reg_ctx]};
            RG_PMASK:  rd_mux = {{(DATA_W-PRIO_W){1'b0}}, pmask_a[reg_ctx]};
            RG_BINPT:  rd_mux = {{(DATA_W-BINPT_W){1'b0}}, binpt_a[reg_ctx]};
            RG_ACK:    rd_mux = ack_ok[reg_ctx]
                                ? pack_ack(rec_src_a[reg_ctx], rec_id_a[reg_ctx])
                                : {{(DATA_W-ID_W){1'b0}}, SPUR_ID};
            RG_RUNPRI: rd_mux = {{(DATA_W-PRIO_W){1'b0}}, runpri_a[reg_ctx]};
            default:   rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rvalid <= 1'b0;
         reg_rdata  <= '0;
      end else begin
         reg_rvalid <= reg_valid && !reg_write;
         reg_rdata  <= (reg_valid && !reg_write) ? rd_mux : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_valid <= 1'b0;
         clr_id    <= '0;
         clr_src   <= '0;
         clr_ctx   <= '0;
         eval_req  <= '0;
      end else begin
         clr_valid <= ack_any;
         clr_id    <= ack_any ? rec_id_a[reg_ctx]  : '0;
         clr_src   <= ack_any ? rec_src_a[reg_ctx] : '0;
         clr_ctx   <= ack_any ? reg_ctx : '0;
         eval_req  <= (wr_any & new_en) | ack_ok;
      end
   end
endmodule

// File: rtl/irq_cpuif_chk.sv
module irq_cpuif_chk
   import cpuif_pkg::*;
#(
   parameter int unsigned NUM_CPUS = 4,
   parameter int unsigned NUM_INTS = 64,
   parameter bit          IRQ_REG  = 1'b0,
   parameter int unsigned CTX_W    = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_valid,
   input logic                  reg_write,
   input logic [ADDR_W-1:0]     reg_addr,
   input logic                  reg_rvalid,
   input logic [DATA_W-1:0]     reg_rdata,
   input logic                  dist_enable,
   input logic [NUM_CPUS-1:0]   irq,
   input logic [NUM_CPUS-1:0]   eval_req,
   input logic                  clr_valid,
   input logic [CTX_W-1:0]      clr_ctx,
   input logic                  eoi_valid,
   input logic [ID_W-1:0]       eoi_id,
   input logic [SGI_MASK_W-1:0] eoi_sgi_mask,
   input logic [NUM_INTS-1:0]   active
);
   localparam logic [ID_W-1:0] INT_LIM = ID_W'(NUM_INTS);

   assert_irq_needs_dist_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!dist_enable && !$past(dist_enable)) |-> (irq == '0));

   assert_rvalid_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && !reg_write) |=> reg_rvalid);

   assert_ack_disabled_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rvalid && $past(reg_addr == RG_ACK && !dist_enable)) |-> (reg_rdata == 32'd1023));

   assert_clr_from_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_valid |-> $past(reg_valid && !reg_write && reg_addr == RG_ACK));

   if (!IRQ_REG) begin : g_irq_drop
      assert_clr_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
         clr_valid |-> !irq[clr_ctx]);
   end

   assert_sgi_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eoi_sgi_mask));

   assert_sgi_low_ids_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_sgi_mask != '0) |-> (eoi_valid && eoi_id < SGI_LIMIT));

   assert_active_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && eoi_id >= SGI_LIMIT && eoi_id < INT_LIM) |-> !active[eoi_id]);

   assert_eval_on_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clr_valid |-> eval_req[clr_ctx]);
endmodule

bind irq_cpuif irq_cpuif_chk #(
   .NUM_CPUS(NUM_CPUS), .NUM_INTS(NUM_INTS), .IRQ_REG(IRQ_REG), .CTX_W(CTX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
   .reg_addr(reg_addr), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
   .dist_enable(dist_enable), .irq(irq), .eval_req(eval_req),
   .clr_valid(clr_valid), .clr_ctx(clr_ctx), .eoi_valid(eoi_valid),
   .eoi_id(eoi_id), .eoi_sgi_mask(eoi_sgi_mask), .active(active)
);

// File: tb/irq_cpuif_test.sv
module irq_cpuif_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0;
   logic        reg_write = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [1:0]  reg_ctx = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_rvalid;
   logic [31:0] reg_rdata;
   logic        dist_enable = 1'b0;
   logic [3:0]  hp_load = '0;
   logic [39:0] hp_id = {4{10'd1023}};
   logic [11:0] hp_src = '0;
   logic [31:0] hp_prio = '1;
   logic [3:0]  irq, eval_req;
   logic        clr_valid, eoi_valid;
   logic [9:0]  clr_id, eoi_id;
   logic [2:0]  clr_src;
   logic [1:0]  clr_ctx;
   logic [63:0] eoi_sgi_mask, active;

   int checks = 0;
   int errors = 0;

   irq_cpuif uut (
      .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
      .reg_addr(reg_addr), .reg_ctx(reg_ctx), .reg_wdata(reg_wdata),
      .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata), .dist_enable(dist_enable),
      .hp_load(hp_load), .hp_id(hp_id), .hp_src(hp_src), .hp_prio(hp_prio),
      .irq(irq), .eval_req(eval_req), .clr_valid(clr_valid), .clr_id(clr_id),
      .clr_src(clr_src), .clr_ctx(clr_ctx), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
      .eoi_sgi_mask(eoi_sgi_mask), .active(active)
   );

   always #5 clk = ~clk;

   // reference model state
   int m_en[4], m_pmask[4], m_binpt[4], m_runpri[4], m_id[4], m_src[4], m_prio[4];
   logic [63:0] m_active;
   logic        m_rvalid, m_clr_valid, m_eoi_valid;
   logic [31:0] m_rdata;
   logic [9:0]  m_clr_id, m_eoi_id;
   logic [2:0]  m_clr_src;
   logic [1:0]  m_clr_ctx;
   logic [63:0] m_eoi_mask;
   logic [3:0]  m_eval;
   string       m_rtag = "R3";

   task automatic chk(input bit good, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!good) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin : model
      int c, eid, esrc;
      bit ok;
      logic [3:0] ackd;
      if (!rst_n) begin
         for (int k = 0; k < 4; k++) begin
            m_en[k] = 0; m_pmask[k] = 0; m_binpt[k] = 0; m_runpri[k] = 255;
            m_id[k] = 1023; m_src[k] = 0; m_prio[k] = 255;
         end
         m_active = '0; m_rvalid = 0; m_rdata = '0; m_clr_valid = 0; m_clr_id = '0;
         m_clr_src = '0; m_clr_ctx = '0; m_eoi_valid = 0; m_eoi_id = '0;
         m_eoi_mask = '0; m_eval = '0;
      end else begin
         m_rvalid = 0; m_rdata = '0; m_clr_valid = 0; m_clr_id = '0; m_clr_src = '0;
         m_clr_ctx = '0; m_eoi_valid = 0; m_eoi_id = '0; m_eoi_mask = '0; m_eval = '0;
         ackd = '0;
         if (reg_valid) begin
            c  = int'(reg_ctx);
            ok = dist_enable && m_en[c] != 0 && m_id[c] != 1023;
            if (!reg_write) begin
               m_rvalid = 1;
               case (reg_addr)
                  4'd0: begin m_rdata = m_en[c];    m_rtag = "R2"; end
                  4'd1: begin m_rdata = m_pmask[c]; m_rtag = "R2"; end
                  4'd2: begin m_rdata = m_binpt[c]; m_rtag = "R2"; end
                  4'd5: begin m_rdata = m_runpri[c]; m_rtag = "R12"; end
                  4'd3: begin
                     if (ok) begin
                        m_rdata = (m_src[c] << 10) | m_id[c];
                        m_rtag = "R6";
                        ackd[c] = 1'b1;
                        m_clr_valid = 1; m_clr_id = 10'(m_id[c]);
                        m_clr_src = 3'(m_src[c]); m_clr_ctx = 2'(c);
                        m_eval[c] = 1'b1;
                        m_runpri[c] = m_prio[c];
                        if (m_id[c] >= 16 && m_id[c] < 64) m_active[m_id[c]] = 1'b1;
                        m_id[c] = 1023;
                     end else begin
                        m_rdata = 32'd1023; m_rtag = "R5";
                     end
                  end
                  default: begin m_rdata = '0; m_rtag = "R3"; end
               endcase
            end else begin
               case (reg_addr)
                  4'd0: m_en[c]    = int'(reg_wdata[0]);
                  4'd1: m_pmask[c] = int'(reg_wdata[7:0]);
                  4'd2: m_binpt[c] = int'(reg_wdata[2:0]);
                  4'd4: begin
                     eid  = int'(reg_wdata[9:0]);
                     esrc = int'(reg_wdata[12:10]);
                     m_eoi_valid = 1; m_eoi_id = 10'(eid);
                     if (eid < 16) m_eoi_mask[c + 8*esrc] = 1'b1;
                     else if (eid < 64) m_active[eid] = 1'b0;
                     m_runpri[c] = 255;
                  end
                  default: ;
               endcase
               if (m_en[c] != 0) m_eval[c] = 1'b1;
            end
         end
         for (int k = 0; k < 4; k++) begin
            if (hp_load[k] && !ackd[k]) begin
               m_id[k]   = int'(hp_id[k*10 +: 10]);
               m_src[k]  = int'(hp_src[k*3 +: 3]);
               m_prio[k] = int'(hp_prio[k*8 +: 8]);
            end
         end
      end
   end

   // compare every cycle, away from the rising edge
   always @(negedge clk) begin
      if (rst_n) begin
         for (int k = 0; k < 4; k++) begin
            chk(irq[k] === (m_id[k] != 1023 && dist_enable && m_en[k] != 0 && m_prio[k] < m_pmask[k]),
                "R4", "irq", 64'(irq[k]), 64'(m_id[k] != 1023 && dist_enable && m_en[k] != 0 && m_prio[k] < m_pmask[k]));
         end
         chk(reg_rvalid === m_rvalid, "R3", "rvalid", 64'(reg_rvalid), 64'(m_rvalid));
         chk(reg_rdata === m_rdata, m_rtag, "rdata", 64'(reg_rdata), 64'(m_rdata));
         chk({clr_valid, clr_id, clr_src, clr_ctx} === {m_clr_valid, m_clr_id, m_clr_src, m_clr_ctx},
             "R6", "clear pulse", 64'({clr_valid, clr_id, clr_src, clr_ctx}),
             64'({m_clr_valid, m_clr_id, m_clr_src, m_clr_ctx}));
         chk({eoi_valid, eoi_id} === {m_eoi_valid, m_eoi_id}, "R9", "eoi pulse",
             64'({eoi_valid, eoi_id}), 64'({m_eoi_valid, m_eoi_id}));
         chk(eoi_sgi_mask === m_eoi_mask, "R8", "sgi mask", eoi_sgi_mask, m_eoi_mask);
         chk(active === m_active, "R10", "active", active, m_active);
         chk(eval_req === m_eval, "R11", "eval_req", 64'(eval_req), 64'(m_eval));
      end
   end

   task automatic step(input bit v, input bit w, input logic [3:0] a, input int c,
                       input logic [31:0] d, input logic [3:0] ld);
      @(posedge clk); #2;
      reg_valid = v; reg_write = w; reg_addr = a; reg_ctx = 2'(c);
      reg_wdata = d; hp_load = ld;
   endtask

   task automatic idle();
      step(0, 0, 4'd0, 0, 32'd0, 4'd0);
   endtask

   task automatic set_hp(input int c, input int id, input int src, input int prio);
      hp_id[c*10 +: 10] = 10'(id);
      hp_src[c*3 +: 3]  = 3'(src);
      hp_prio[c*8 +: 8] = 8'(prio);
   endtask

   task automatic rd_expect(input logic [3:0] a, input int c, input logic [31:0] e,
                            input string tag);
      step(1, 0, a, c, 32'd0, 4'd0);
      idle();
      @(negedge clk);
      chk(reg_rdata === e, tag, "directed read", 64'(reg_rdata), 64'(e));
   endtask

   task automatic run_random(input int n);
      int c, sel, id, src;
      logic [3:0]  a;
      logic [31:0] d;
      for (int k = 0; k < n; k++) begin
         c   = $urandom_range(0, 3);
         sel = $urandom_range(0, 7);
         case (sel)
            0: a = 4'd0; 1: a = 4'd1; 2: a = 4'd2; 3: a = 4'd3;
            4: a = 4'd4; 5: a = 4'd5; 6: a = 4'd15; default: a = 4'd3;
         endcase
         id  = $urandom_range(0, 3) == 0 ? $urandom_range(0, 15) : $urandom_range(16, 70);
         src = $urandom_range(0, 7);
         d   = (a == 4'd4) ? 32'((src << 10) | id) : (a == 4'd0 ? 32'($urandom_range(0, 3) != 0) : $urandom());
         step($urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1, a, c, d, 4'($urandom_range(0, 15)));
         for (int q = 0; q < 4; q++)
            set_hp(q, $urandom_range(0, 9) == 0 ? 1023 : $urandom_range(0, 70),
                   $urandom_range(0, 7), $urandom_range(0, 255));
         if ($urandom_range(0, 49) == 0) dist_enable = ~dist_enable;
      end
      idle();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      chk(irq === 4'd0 && active === 64'd0 && !clr_valid && !eoi_valid && eval_req === 4'd0,
          "R1", "reset outputs", 64'({irq, clr_valid, eoi_valid, eval_req}), 64'd0);
      rd_expect(4'd5, 2, 32'hFF, "R1");
      rd_expect(4'd3, 0, 32'd1023, "R1");

      // R2: per-context storage
      step(1, 1, 4'd0, 0, 32'h1, 4'd0);
      step(1, 1, 4'd1, 0, 32'hF0, 4'd0);
      step(1, 1, 4'd2, 0, 32'hFD, 4'd0);
      step(1, 1, 4'd1, 1, 32'h33, 4'd0);
      rd_expect(4'd1, 0, 32'hF0, "R2");
      rd_expect(4'd2, 0, 32'h5, "R2");
      rd_expect(4'd1, 1, 32'h33, "R2");
      rd_expect(4'd15, 0, 32'd0, "R3");
      rd_expect(4'd4, 0, 32'd0, "R3");

      // R4, R6, R10: ordinary interrupt acknowledged on context 0
      dist_enable = 1'b1;
      set_hp(0, 40, 0, 8'h20);
      step(0, 0, 4'd0, 0, 32'd0, 4'b0001);
      idle();
      @(negedge clk);
      chk(irq[0] === 1'b1, "R4", "irq after load", 64'(irq[0]), 64'd1);
      step(1, 1, 4'd1, 0, 32'h10, 4'd0);
      idle();
      @(negedge clk);
      chk(irq[0] === 1'b0, "R4", "irq masked", 64'(irq[0]), 64'd0);
      step(1, 1, 4'd1, 0, 32'hF0, 4'd0);
      rd_expect(4'd3, 0, 32'd40, "R6");
      chk(active[40] === 1'b1, "R10", "active set", 64'(active[40]), 64'd1);
      rd_expect(4'd5, 0, 32'h20, "R12");
      rd_expect(4'd3, 0, 32'd1023, "R5");
      step(1, 1, 4'd4, 0, 32'd40, 4'd0);
      idle();
      @(negedge clk);
      chk(active[40] === 1'b0, "R9", "active cleared", 64'(active[40]), 64'd0);
      rd_expect(4'd5, 0, 32'hFF, "R9");

      // R8: software interrupt on context 1 from source 2
      step(1, 1, 4'd0, 1, 32'h1, 4'd0);
      step(1, 1, 4'd1, 1, 32'hFF, 4'd0);
      set_hp(1, 3, 2, 8'h10);
      step(0, 0, 4'd0, 0, 32'd0, 4'b0010);
      rd_expect(4'd3, 1, 32'h803, "R6");
      step(1, 1, 4'd4, 1, 32'h803, 4'd0);
      idle();
      @(negedge clk);
      chk(eoi_sgi_mask === 64'h20000, "R8", "sgi mask bit 17", eoi_sgi_mask, 64'h20000);

      // R5: global enable off leaves the record alone
      set_hp(1, 50, 1, 8'h08);
      step(0, 0, 4'd0, 0, 32'd0, 4'b0010);
      dist_enable = 1'b0;
      rd_expect(4'd3, 1, 32'd1023, "R5");
      dist_enable = 1'b1;
      rd_expect(4'd3, 1, 32'h432, "R5");

      // R7: load and acknowledge in the same cycle, acknowledge wins
      set_hp(0, 20, 0, 8'h01);
      step(0, 0, 4'd0, 0, 32'd0, 4'b0001);
      idle();
      set_hp(0, 21, 0, 8'h02);
      step(1, 0, 4'd3, 0, 32'd0, 4'b0001);
      idle();
      @(negedge clk);
      chk(reg_rdata === 32'd20, "R7", "ack of first record", 64'(reg_rdata), 64'd20);
      rd_expect(4'd3, 0, 32'd1023, "R7");

      // R11: a write with the enable clear raises no evaluation request
      step(1, 1, 4'd0, 2, 32'h0, 4'd0);
      idle();
      @(negedge clk);
      chk(eval_req[2] === 1'b0, "R11", "no eval when disabled", 64'(eval_req[2]), 64'd0);

      run_random(4000);
      repeat (3) @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule